// File: doc/BRIEF.md
# Quad Wiper Position Controller

This block keeps the digital control state for two resistor-ladder potentiometers with two wipers each, so four wipers in all. Every wiper has an 8-bit position register that picks one of 256 taps on a chain of 255 series elements. The position drives a registered one-hot tap-select vector that an analog switch array can use directly. Next to each position register sits a bank of four retained data registers. A host can write and read these registers, copy one into the position register, or store the current position into one.

A host issues single-cycle commands on a parallel command port. Each command carries a 2-bit opcode, a 2-bit wiper index and a 2-bit register index. A second, independent port moves one wiper a single step per falling edge of its active-low select. A write-protect input blocks every change to the data registers. Any accepted change to a data register starts a busy window, and its length is set by an input. When reset is released, every wiper recalls data register 0 of its own bank.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: In the first clock after reset release, each position register loads data register 0 of its own bank; commands are ignored in that cycle; data register 0 resets to 0x10, 0x40, 0x80, 0xC0 for wipers 0..3 and the other data registers reset to 0.
- R2: An accepted write command (opcode 0) stores cmd_wdata_i into data register cmd_reg_i of wiper cmd_wiper_i.
- R3: An accepted read command (opcode 1) presents the addressed data register on rd_data_o with rd_valid_o high for exactly the one cycle after the command edge.
- R4: An accepted transfer command (opcode 2) copies the addressed data register into the wiper's position register at the command edge and does not start the busy window.
- R5: An accepted save command (opcode 3) copies the wiper's position register into the addressed data register.
- R6: While wp_i is high, write and save commands change no data register and start no busy window; transfer and read still work.
- R7: An accepted write or save raises busy_o for exactly busy_cycles_i cycles, starting the cycle after the command edge.
- R8: While busy_o is high, every command (write, read, transfer, save) is rejected and has no effect.
- R9: A falling edge of ud_cs_ni raises the wiper chosen by ud_sel_i by one when ud_dir_i is 1 and lowers it by one when ud_dir_i is 0; the other wipers do not move.
- R10: Stepping saturates: a step up at 255 and a step down at 0 leave the position unchanged.
- R11: tap_o bit w*256+p is set exactly when wiper w sits at position p; it is one-hot per wiper and follows a position change one clock later.
- R12: When a transfer and a step hit the same wiper in the same cycle, the transfer wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wp_i | input | 1 | Write protect for the data registers |
| busy_cycles_i | input | 8 | Busy window length in cycles |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 2 | 0 write, 1 read, 2 transfer, 3 save |
| cmd_wiper_i | input | 2 | Target wiper index |
| cmd_reg_i | input | 2 | Target data register index |
| cmd_wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 8 | Read data |
| busy_o | output | 1 | Data register busy window |
| ud_cs_ni | input | 1 | Step select, active low; a falling edge steps |
| ud_dir_i | input | 1 | Step direction, 1 up, 0 down |
| ud_sel_i | input | 2 | Wiper to step |
| pos_o | output | 32 | Positions, wiper w at bits w*8+7:w*8 |
| tap_o | output | 1024 | One-hot tap selects, wiper w at bits w*256+255:w*256 |

## Verification
Data register writes, transfers, saves and steps all take effect at the clock edge that samples the command, or the low ud_cs_ni. Reads, position changes and busy_o are therefore checked in the low phase right after that edge, while tap_o is checked one clock later. The busy window is measured by counting low phases with busy_o high, starting the cycle after the command edge, which has to equal busy_cycles_i. Rejected and blocked commands are confirmed at the ports. The bench reads the addressed register back, or watches pos_o and rd_valid_o, once busy_o has dropped.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_XFER  = 2'd2,
    OP_SAVE  = 2'd3
  } wiper_op_e;
endpackage

// File: rtl/wiper_busy_timer.sv
module wiper_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i); // R8
  AST_BUSY_DECAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q < $past(cnt_q))); // R7
endmodule

// File: rtl/wiper_step_port.sv
module wiper_step_port #(
  parameter int NUM_WIPERS = 4,
  localparam int SEL_W = $clog2(NUM_WIPERS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  dir_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic [NUM_WIPERS-1:0] up_o,
  output logic [NUM_WIPERS-1:0] dn_o
);
  logic cs_q;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b1;
    else         cs_q <= cs_ni;
  end

  assign fall = cs_q & ~cs_ni;

  for (genvar w = 0; w < NUM_WIPERS; w++) begin : g_sel
    assign up_o[w] = fall &  dir_i & (sel_i == SEL_W'(w));
    assign dn_o[w] = fall & ~dir_i & (sel_i == SEL_W'(w));
  end

  AST_STEP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(up_o | dn_o)); // R9
  AST_STEP_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(up_o | dn_o)) |=> !(|(up_o | dn_o))); // R9
endmodule

// File: rtl/wiper_channel.sv
module wiper_channel #(
  parameter int          POS_W    = 8,
  parameter int          NUM_REGS = 4,
  parameter logic [POS_W-1:0] INIT0 = '0,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int TAPS  = 1 << POS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             recall_i,
  input  logic             dr_we_i,
  input  logic             save_i,
  input  logic             xfer_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [POS_W-1:0] wdata_i,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  output logic [POS_W-1:0] pos_o,
  output logic [TAPS-1:0]  tap_o,
  output logic [POS_W-1:0] rdata_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] dr_q [NUM_REGS];
  logic [POS_W-1:0] pos_q;
  logic [TAPS-1:0]  tap_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dr
    localparam logic [POS_W-1:0] RST_VAL = (r == 0) ? INIT0 : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               dr_q[r] <= RST_VAL;
      else if (dr_we_i && idx_i == IDX_W'(r))    dr_q[r] <= wdata_i;
      else if (save_i && idx_i == IDX_W'(r))     dr_q[r] <= pos_q;
    end
  end

  assign rdata_o = dr_q[idx_i];

  // recall, then host transfer, then step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             pos_q <= '0;
    else if (recall_i)                       pos_q <= dr_q[0];
    else if (xfer_i)                         pos_q <= dr_q[idx_i];
    else if (step_up_i && pos_q != POS_MAX)  pos_q <= pos_q + 1'b1;
    else if (step_dn_i && pos_q != '0)       pos_q <= pos_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= TAPS'(1);
    else         tap_q <= TAPS'(1) << pos_q;
  end

  assign pos_o = pos_q;
  assign tap_o = tap_q;

  AST_NO_WRAP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_up_i && pos_q == POS_MAX && !xfer_i && !recall_i) |=> pos_q == POS_MAX); // R10
  AST_NO_WRAP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_dn_i && pos_q == '0 && !xfer_i && !recall_i) |=> pos_q == '0); // R10
  AST_TAP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tap_q) == 1); // R11
  AST_XFER_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !recall_i) |=> pos_q == $past(rdata_o)); // R12
endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl
  import wiper_pkg::*;
#(
  parameter int NUM_WIPERS = 4,
  parameter int NUM_REGS   = 4,
  parameter int POS_W      = 8,
  parameter int BUSY_W     = 8,
  parameter logic [NUM_WIPERS*POS_W-1:0] DR_INIT = 32'hC080_4010,
  localparam int WSEL_W = $clog2(NUM_WIPERS),
  localparam int RSEL_W = $clog2(NUM_REGS),
  localparam int TAPS   = 1 << POS_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wp_i,
  input  logic [BUSY_W-1:0]          busy_cycles_i,
  input  logic                       cmd_valid_i,
  input  logic [1:0]                 cmd_op_i,
  input  logic [WSEL_W-1:0]          cmd_wiper_i,
  input  logic [RSEL_W-1:0]          cmd_reg_i,
  input  logic [POS_W-1:0]           cmd_wdata_i,
  output logic                       rd_valid_o,
  output logic [POS_W-1:0]           rd_data_o,
  output logic                       busy_o,
  input  logic                       ud_cs_ni,
  input  logic                       ud_dir_i,
  input  logic [WSEL_W-1:0]          ud_sel_i,
  output logic [NUM_WIPERS*POS_W-1:0] pos_o,
  output logic [NUM_WIPERS*TAPS-1:0]  tap_o
);
  wiper_op_e op;
  logic      recall_q;
  logic      cmd_ok;
  logic      rd_go;
  logic      busy_start;
  logic      rd_valid_q;
  logic [POS_W-1:0] rd_data_q;

  logic [NUM_WIPERS-1:0] dr_we, save, xfer, step_up, step_dn;
  logic [POS_W-1:0]      ch_rdata [NUM_WIPERS];

  assign op = wiper_op_e'(cmd_op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) recall_q <= 1'b1;
    else         recall_q <= 1'b0;
  end

  assign cmd_ok = cmd_valid_i & ~busy_o & ~recall_q;
  assign rd_go  = cmd_ok & (op == OP_READ);

  for (genvar w = 0; w < NUM_WIPERS; w++) begin : g_dec
    logic hit;
    assign hit       = cmd_ok & (cmd_wiper_i == WSEL_W'(w));
    assign dr_we[w]  = hit & (op == OP_WRITE) & ~wp_i;
    assign save[w]   = hit & (op == OP_SAVE)  & ~wp_i;
    assign xfer[w]   = hit & (op == OP_XFER);
  end

  assign busy_start = |(dr_we | save);

  wiper_busy_timer #(.CNT_W(BUSY_W)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (busy_start),
    .len_i   (busy_cycles_i),
    .busy_o  (busy_o)
  );

  wiper_step_port #(.NUM_WIPERS(NUM_WIPERS)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (ud_cs_ni),
    .dir_i  (ud_dir_i),
    .sel_i  (ud_sel_i),
    .up_o   (step_up),
    .dn_o   (step_dn)
  );

  for (genvar w = 0; w < NUM_WIPERS; w++) begin : g_ch
    wiper_channel #(
      .POS_W    (POS_W),
      .NUM_REGS (NUM_REGS),
      .INIT0    (DR_INIT[w*POS_W +: POS_W])
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .recall_i  (recall_q),
      .dr_we_i   (dr_we[w]),
      .save_i    (save[w]),
      .xfer_i    (xfer[w]),
      .idx_i     (cmd_reg_i),
      .wdata_i   (cmd_wdata_i),
      .step_up_i (step_up[w]),
      .step_dn_i (step_dn[w]),
      .pos_o     (pos_o[w*POS_W +: POS_W]),
      .tap_o     (tap_o[w*TAPS +: TAPS]),
      .rdata_o   (ch_rdata[w])
    );

    AST_RECALL_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(recall_q) |-> pos_o[w*POS_W +: POS_W] == DR_INIT[w*POS_W +: POS_W]); // R1
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_go;
      if (rd_go) rd_data_q <= ch_rdata[cmd_wiper_i];
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  AST_WP_BLOCKS_DR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |-> !(|(dr_we | save))); // R6
  AST_READ_REJECT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == OP_READ && busy_o) |=> !rd_valid_o); // R8
  AST_XFER_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && op == OP_XFER) |=> !busy_o); // R4
endmodule

// File: tb/wiper_bank_ctrl_test.sv
module wiper_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp = 1'b0;
  logic [7:0]  busy_len = 8'd3;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [1:0]  cmd_wiper = '0;
  logic [1:0]  cmd_reg = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        busy;
  logic        ud_cs_n = 1'b1;
  logic        ud_dir = 1'b0;
  logic [1:0]  ud_sel = '0;
  logic [31:0]   pos;
  logic [1023:0] tap;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wiper_bank_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .busy_cycles_i(busy_len),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_wiper_i(cmd_wiper),
    .cmd_reg_i(cmd_reg), .cmd_wdata_i(cmd_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .busy_o(busy),
    .ud_cs_ni(ud_cs_n), .ud_dir_i(ud_dir), .ud_sel_i(ud_sel),
    .pos_o(pos), .tap_o(tap)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wpos(int w);
    return pos[w*8 +: 8];
  endfunction

  task automatic check_tap(string req, int w, int p);
    check(req, {31'd0, tap[w*256 + p]}, 32'd1);
    check(req, $countones(tap[w*256 +: 256]), 32'd1);
  endtask

  // all tasks start and end in the low phase
  task automatic do_cmd(logic [1:0] op, logic [1:0] w, logic [1:0] r, logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_wiper = w; cmd_reg = r; cmd_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic step(logic [1:0] w, logic dir);
    ud_sel = w; ud_dir = dir; ud_cs_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ud_cs_n = 1'b1;
  endtask

  task automatic settle_cs();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_check(string req, logic [1:0] w, logic [1:0] r, logic [7:0] exp);
    do_cmd(2'd1, w, r, 8'h00);
    check(req, {31'd0, rd_valid}, 32'd1);
    check(req, {24'd0, rd_data}, {24'd0, exp});
  endtask

  task automatic t_reset();
    check("R1 busy at reset", {31'd0, busy}, 32'd0);
    check("R1 rd_valid at reset", {31'd0, rd_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    settle_cs(); settle_cs();
    check("R1 w0", {24'd0, wpos(0)}, 32'h10);
    check("R1 w1", {24'd0, wpos(1)}, 32'h40);
    check("R1 w2", {24'd0, wpos(2)}, 32'h80);
    check("R1 w3", {24'd0, wpos(3)}, 32'hC0);
    check_tap("R11 reset tap w2", 2, 'h80);
    read_check("R1 other regs zero", 2'd2, 2'd3, 8'h00);
  endtask

  task automatic t_write_read();
    busy_len = 8'd3;
    do_cmd(2'd0, 2'd1, 2'd2, 8'h5A);
    check("R7 busy after write", {31'd0, busy}, 32'd1);
    wait_idle();
    read_check("R2 R3 write then read", 2'd1, 2'd2, 8'h5A);
    @(negedge clk);
    check("R3 rd_valid one cycle", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_busy_len();
    int n = 0;
    busy_len = 8'd5;
    do_cmd(2'd0, 2'd2, 2'd1, 8'h21);
    while (busy && n < 50) begin n++; @(negedge clk); end
    check("R7 busy length", n, 32'd5);
  endtask

  task automatic t_busy_reject();
    busy_len = 8'd5;
    do_cmd(2'd0, 2'd0, 2'd3, 8'h44);
    do_cmd(2'd0, 2'd0, 2'd1, 8'h77);
    do_cmd(2'd1, 2'd0, 2'd3, 8'h00);
    check("R8 read rejected while busy", {31'd0, rd_valid}, 32'd0);
    do_cmd(2'd2, 2'd0, 2'd3, 8'h00);
    check("R8 transfer rejected while busy", {24'd0, wpos(0)}, 32'h10);
    wait_idle();
    read_check("R8 write rejected while busy", 2'd0, 2'd1, 8'h00);
    read_check("R2 first write kept", 2'd0, 2'd3, 8'h44);
  endtask

  task automatic t_xfer();
    do_cmd(2'd2, 2'd0, 2'd3, 8'h00);
    check("R4 transfer", {24'd0, wpos(0)}, 32'h44);
    check("R4 no busy", {31'd0, busy}, 32'd0);
    check_tap("R11 tap lags one clock", 0, 'h10);
    @(negedge clk);
    check_tap("R11 tap follows", 0, 'h44);
  endtask

  task automatic t_save();
    step(2'd0, 1'b1);
    settle_cs();
    check("R9 step up", {24'd0, wpos(0)}, 32'h45);
    do_cmd(2'd3, 2'd0, 2'd2, 8'h00);
    check("R7 busy after save", {31'd0, busy}, 32'd1);
    wait_idle();
    read_check("R5 save", 2'd0, 2'd2, 8'h45);
  endtask

  task automatic t_wp();
    wp = 1'b1;
    do_cmd(2'd0, 2'd3, 2'd1, 8'h99);
    check("R6 no busy on blocked write", {31'd0, busy}, 32'd0);
    read_check("R6 write blocked", 2'd3, 2'd1, 8'h00);
    do_cmd(2'd3, 2'd3, 2'd2, 8'h00);
    check("R6 no busy on blocked save", {31'd0, busy}, 32'd0);
    read_check("R6 save blocked", 2'd3, 2'd2, 8'h00);
    do_cmd(2'd2, 2'd3, 2'd1, 8'h00);
    check("R6 transfer under protect", {24'd0, wpos(3)}, 32'h00);
    wp = 1'b0;
  endtask

  task automatic t_step();
    step(2'd2, 1'b0);
    settle_cs();
    check("R9 step down w2", {24'd0, wpos(2)}, 32'h7F);
    check("R9 w0 unmoved", {24'd0, wpos(0)}, 32'h45);
    check("R9 w1 unmoved", {24'd0, wpos(1)}, 32'h40);
    step(2'd1, 1'b1);
    settle_cs();
    check("R9 step up w1", {24'd0, wpos(1)}, 32'h41);
    check("R9 w2 unmoved", {24'd0, wpos(2)}, 32'h7F);
    ud_cs_n = 1'b1;
    settle_cs();
    check("R9 no step without edge", {24'd0, wpos(1)}, 32'h41);
  endtask

  task automatic t_sat();
    busy_len = 8'd2;
    do_cmd(2'd0, 2'd1, 2'd3, 8'hFF);
    wait_idle();
    do_cmd(2'd2, 2'd1, 2'd3, 8'h00);
    check("R4 transfer ff", {24'd0, wpos(1)}, 32'hFF);
    step(2'd1, 1'b1);
    settle_cs();
    check("R10 saturate high", {24'd0, wpos(1)}, 32'hFF);
    check_tap("R11 top tap", 1, 255);
    step(2'd3, 1'b0);
    settle_cs();
    check("R10 saturate low", {24'd0, wpos(3)}, 32'h00);
    check_tap("R11 bottom tap", 3, 0);
  endtask

  task automatic t_prio();
    ud_sel = 2'd1; ud_dir = 1'b1; ud_cs_n = 1'b0;
    do_cmd(2'd2, 2'd1, 2'd0, 8'h00);
    ud_cs_n = 1'b1;
    check("R12 transfer beats step", {24'd0, wpos(1)}, 32'h40);
    settle_cs();
    check("R12 no late step", {24'd0, wpos(1)}, 32'h40);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_write_read();
    t_busy_len();
    t_busy_reject();
    t_xfer();
    t_save();
    t_wp();
    t_step();
    t_sat();
    t_prio();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule